// File: doc/BRIEF.md
# ADC Dual-Group Conversion Sequencer

This block steps an analog-to-digital converter through programmed lists of conversions. It keeps two independent ordered lists. The regular group is long, up to sixteen slots, and its results all land in one shared data register. The injected group is short, up to four slots, and each of its slots has its own result register. For every slot the sequencer drives the channel number to the analog front end. It then holds a sampling window whose length comes from that channel's own sample-time code, waits out a fixed eleven-cycle conversion phase, and captures the converter's output word.

Software programs the block through a small write-only configuration port and starts a group with a one-cycle start pulse. A regular result can raise a DMA request, which stays up until the DMA controller acknowledges it. Injected results never request DMA. If software rewrites a group's sequence while a conversion is running, the running conversion is dropped and the rewritten group starts again from its first slot.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, `busy`, `eocReg`, `eocInj` and `dmaReq` are 0, `regData` and `injData` are 0, and `chSel` is 0.
- R2: The regular group converts L+1 slots, where L is the 4-bit value written to config address 1. It works through them in slot order. Address 2 holds the channel fields for slots 0..7 and address 3 holds those for slots 8..15. Each field is 4 bits wide, and slot k of a word sits at bits [4k+3:4k]. A field above 9 selects channel 9, and `chSel` never leaves 0..9 while the block is busy.
- R3: The injected group is set up at address 4. Slot k's channel sits at bits [4k+3:4k] for k = 0..3, and bits [17:16] hold M. The group converts M+1 slots, and the result of slot k goes to `injData[12k+11:12k]`. The other slices keep their values.
- R4: Channel c has a 3-bit sample code at address 5, bits [3c+2:3c]. A code S gives a sampling window of N = 3+4·S cycles with `smpActive` high, followed by exactly 11 cycles with `cnvActive` high. The result is registered on the (N+11)th clock edge after the edge that accepts the start. The next slot's sampling window begins on that same edge.
- R5: `eocReg` (regular) or `eocInj` (injected) is a one-cycle pulse in the cycle its result register shows the new value. The result is `adcData` as sampled on the last conversion cycle of that slot. The two pulses never coincide.
- R6: When bit 0 of address 0 is 1, each regular result sets `dmaReq`. It then stays high until a cycle with `dmaAck` high, and clears on the following edge. When the bit is 0, regular results leave `dmaReq` low.
- R7: Injected results never set `dmaReq`.
- R8: A start pulse on either start input while `busy` is high is ignored. The running group completes on its normal schedule.
- R9: A write to address 1, 2, 3 or 4 while `busy` is high aborts the running conversion without producing a result. The edge of that write restarts the rewritten group at slot 0, with the timing of R4. Writes to addresses 0 and 5 do not abort, and no write starts a conversion while the block is idle.
- R10: When `startReg` and `startInj` are high in the same idle cycle, the injected group runs.
- R11: `busy` is high from the cycle after a start is accepted until the group's last result. It is low in the cycle in which the last result pulse is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration word address |
| cfgWdata | input | 32 | Configuration write data |
| startReg | input | 1 | Start pulse for the regular group |
| startInj | input | 1 | Start pulse for the injected group |
| adcData | input | 12 | Output word of the converter stub |
| dmaAck | input | 1 | DMA acknowledge, clears the request |
| chSel | output | 4 | Channel selected at the analog front end |
| smpActive | output | 1 | Sampling window in progress |
| cnvActive | output | 1 | Conversion phase in progress |
| busy | output | 1 | A group is being converted |
| eocReg | output | 1 | Regular result pulse |
| eocInj | output | 1 | Injected result pulse |
| regData | output | 12 | Shared regular result register |
| injData | output | 48 | Four injected result registers, slot 0 in the low bits |
| dmaReq | output | 1 | DMA request for the regular result |

## Verification
The hardest case to reach is a configuration write that arrives in the middle of a long sampling window. It must drop that conversion and restart the other group at slot 0, and the stale result must never appear. To get there, the bench starts a regular group on a channel with the longest sample code and counts a fixed number of cycles into its window. It then writes the injected sequence, and later does the reverse with a regular sequence write against a running injected group. In each case it measures the first result pulse against the write edge and checks that the aborted group's pulse never shows up.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int NUM_CH    = 10;
  localparam int CH_W      = 4;
  localparam int REG_SLOTS = 16;
  localparam int RLEN_W    = 4;
  localparam int INJ_SLOTS = 4;
  localparam int INJ_IDX_W = 2;
  localparam int DATA_W    = 12;
  localparam int SMP_W     = 3;
  localparam int CONV_CYC  = 11;
  localparam int CNT_W     = 5;
  localparam int CFG_AW    = 3;
  localparam int CFG_DW    = 32;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 storeReg;
    logic                 storeInj;
    logic [INJ_IDX_W-1:0] injIdx;
  } seqStrobe_t;

  // Index of the last sampling cycle for a sample code: cycles = 3 + 4*code.
  function automatic logic [CNT_W-1:0] smpLastOf(input logic [SMP_W-1:0] code);
    return CNT_W'(2) + CNT_W'({code, 2'b00});
  endfunction
endpackage

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int P_CNT_W    = CNT_W,
  parameter int P_RLEN_W   = RLEN_W,
  parameter int P_INJIDX_W = INJ_IDX_W,
  parameter int P_CONV_CYC = CONV_CYC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReg,
  input  logic                  startInj,
  input  logic                  seqWrReg,
  input  logic                  seqWrInj,
  input  logic [P_CNT_W-1:0]    smpLast,
  input  logic [P_RLEN_W-1:0]   regLen,
  input  logic [P_INJIDX_W-1:0] injLen,
  output logic [P_RLEN_W-1:0]   slotIdx,
  output logic                  grpInj,
  output logic                  smpActive,
  output logic                  cnvActive,
  output logic                  busy,
  output seqStrobe_t            strobe
);
  localparam logic [P_CNT_W-1:0] CONV_LAST = P_CNT_W'(P_CONV_CYC - 1);

  seqState_t          state;
  logic [P_CNT_W-1:0] cnt;
  logic               abortNow;
  logic               lastSlot;
  logic               convDone;

  always_comb begin
    busy      = (state != ST_IDLE);
    smpActive = (state == ST_SAMPLE);
    cnvActive = (state == ST_CONVERT);
    abortNow  = busy && (seqWrReg || seqWrInj);
    lastSlot  = grpInj ? (slotIdx == P_RLEN_W'(injLen)) : (slotIdx == regLen);
    convDone  = (state == ST_CONVERT) && (cnt == CONV_LAST);
    strobe.storeReg = convDone && !grpInj && !abortNow;
    strobe.storeInj = convDone && grpInj && !abortNow;
    strobe.injIdx   = slotIdx[P_INJIDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      slotIdx <= '0;
      grpInj  <= 1'b0;
    end else if (abortNow) begin
      state   <= ST_SAMPLE;
      grpInj  <= seqWrInj;
      slotIdx <= '0;
      cnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startInj || startReg) begin
            state   <= ST_SAMPLE;
            grpInj  <= startInj;
            slotIdx <= '0;
            cnt     <= '0;
          end
        end
        ST_SAMPLE: begin
          if (cnt >= smpLast) begin
            state <= ST_CONVERT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CONVERT: begin
          if (convDone) begin
            cnt <= '0;
            if (lastSlot) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_SAMPLE;
              slotIdx <= slotIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_dpath.sv
module conv_seq_dpath
  import conv_seq_pkg::*;
#(
  parameter int P_NUM_CH    = NUM_CH,
  parameter int P_CH_W      = CH_W,
  parameter int P_REG_SLOTS = REG_SLOTS,
  parameter int P_RLEN_W    = RLEN_W,
  parameter int P_INJ_SLOTS = INJ_SLOTS,
  parameter int P_INJIDX_W  = INJ_IDX_W,
  parameter int P_DATA_W    = DATA_W,
  parameter int P_SMP_W     = SMP_W,
  parameter int P_CNT_W     = CNT_W,
  parameter int P_CFG_AW    = CFG_AW,
  parameter int P_CFG_DW    = CFG_DW
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWe,
  input  logic [P_CFG_AW-1:0]             cfgAddr,
  input  logic [P_CFG_DW-1:0]             cfgWdata,
  input  logic [P_DATA_W-1:0]             adcData,
  input  logic                            dmaAck,
  input  logic [P_RLEN_W-1:0]             slotIdx,
  input  logic                            grpInj,
  input  seqStrobe_t                      strobe,
  output logic                            seqWrReg,
  output logic                            seqWrInj,
  output logic [P_CNT_W-1:0]              smpLast,
  output logic [P_RLEN_W-1:0]             regLen,
  output logic [P_INJIDX_W-1:0]           injLen,
  output logic [P_CH_W-1:0]               chSel,
  output logic [P_DATA_W-1:0]             regData,
  output logic [P_INJ_SLOTS*P_DATA_W-1:0] injData,
  output logic                            eocReg,
  output logic                            eocInj,
  output logic                            dmaReq
);
  localparam int SLOTS_PER_WORD = P_CFG_DW / P_CH_W;
  localparam int SLOT_WORDS     = P_REG_SLOTS / SLOTS_PER_WORD;
  localparam int A_CTRL   = 0;
  localparam int A_RLEN   = 1;
  localparam int A_RSLOT0 = 2;
  localparam int A_INJ    = A_RSLOT0 + SLOT_WORDS;
  localparam int A_SMP    = A_INJ + 1;
  localparam logic [P_CH_W-1:0] CH_MAX = P_CH_W'(P_NUM_CH - 1);

  logic                                 dmaEn;
  logic [P_REG_SLOTS-1:0][P_CH_W-1:0]   regSlots;
  logic [P_INJ_SLOTS-1:0][P_CH_W-1:0]   injSlots;
  logic [P_NUM_CH-1:0][P_SMP_W-1:0]     smpCode;
  logic [P_INJ_SLOTS-1:0][P_DATA_W-1:0] injRes;
  logic [P_CH_W-1:0]                    rawCh;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEn    <= 1'b0;
      regLen   <= '0;
      regSlots <= '0;
      injSlots <= '0;
      injLen   <= '0;
      smpCode  <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == P_CFG_AW'(A_CTRL)) dmaEn <= cfgWdata[0];
      if (cfgAddr == P_CFG_AW'(A_RLEN)) regLen <= cfgWdata[P_RLEN_W-1:0];
      for (int w = 0; w < SLOT_WORDS; w++) begin
        if (cfgAddr == P_CFG_AW'(A_RSLOT0 + w)) begin
          for (int k = 0; k < SLOTS_PER_WORD; k++)
            regSlots[w*SLOTS_PER_WORD+k] <= cfgWdata[k*P_CH_W +: P_CH_W];
        end
      end
      if (cfgAddr == P_CFG_AW'(A_INJ)) begin
        for (int k = 0; k < P_INJ_SLOTS; k++)
          injSlots[k] <= cfgWdata[k*P_CH_W +: P_CH_W];
        injLen <= cfgWdata[P_INJ_SLOTS*P_CH_W +: P_INJIDX_W];
      end
      if (cfgAddr == P_CFG_AW'(A_SMP)) begin
        for (int c = 0; c < P_NUM_CH; c++)
          smpCode[c] <= cfgWdata[c*P_SMP_W +: P_SMP_W];
      end
    end
  end

  // Sequence-rewrite detection and slot lookup
  always_comb begin
    seqWrReg = cfgWe && ((cfgAddr == P_CFG_AW'(A_RLEN)) ||
               ((cfgAddr >= P_CFG_AW'(A_RSLOT0)) && (cfgAddr < P_CFG_AW'(A_INJ))));
    seqWrInj = cfgWe && (cfgAddr == P_CFG_AW'(A_INJ));
    rawCh    = grpInj ? injSlots[slotIdx[P_INJIDX_W-1:0]] : regSlots[slotIdx];
    chSel    = (rawCh > CH_MAX) ? CH_MAX : rawCh;
    smpLast  = smpLastOf(smpCode[chSel]);
  end

  // Result registers, end-of-conversion pulses, DMA request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regData <= '0;
      injRes  <= '0;
      eocReg  <= 1'b0;
      eocInj  <= 1'b0;
      dmaReq  <= 1'b0;
    end else begin
      eocReg <= strobe.storeReg;
      eocInj <= strobe.storeInj;
      if (strobe.storeReg) regData <= adcData;
      if (strobe.storeInj) injRes[strobe.injIdx] <= adcData;
      if (strobe.storeReg && dmaEn) dmaReq <= 1'b1;
      else if (dmaAck)              dmaReq <= 1'b0;
    end
  end

  for (genvar g = 0; g < P_INJ_SLOTS; g++) begin : gInjOut
    assign injData[g*P_DATA_W +: P_DATA_W] = injRes[g];
  end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import conv_seq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [CFG_AW-1:0]           cfgAddr,
  input  logic [CFG_DW-1:0]           cfgWdata,
  input  logic                        startReg,
  input  logic                        startInj,
  input  logic [DATA_W-1:0]           adcData,
  input  logic                        dmaAck,
  output logic [CH_W-1:0]             chSel,
  output logic                        smpActive,
  output logic                        cnvActive,
  output logic                        busy,
  output logic                        eocReg,
  output logic                        eocInj,
  output logic [DATA_W-1:0]           regData,
  output logic [INJ_SLOTS*DATA_W-1:0] injData,
  output logic                        dmaReq
);
  seqStrobe_t           strobe;
  logic                 seqWrReg;
  logic                 seqWrInj;
  logic [CNT_W-1:0]     smpLast;
  logic [RLEN_W-1:0]    regLen;
  logic [INJ_IDX_W-1:0] injLen;
  logic [RLEN_W-1:0]    slotIdx;
  logic                 grpInj;

  conv_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReg(startReg), .startInj(startInj),
    .seqWrReg(seqWrReg), .seqWrInj(seqWrInj),
    .smpLast(smpLast), .regLen(regLen), .injLen(injLen),
    .slotIdx(slotIdx), .grpInj(grpInj),
    .smpActive(smpActive), .cnvActive(cnvActive), .busy(busy),
    .strobe(strobe)
  );

  conv_seq_dpath u_dpath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .adcData(adcData), .dmaAck(dmaAck),
    .slotIdx(slotIdx), .grpInj(grpInj), .strobe(strobe),
    .seqWrReg(seqWrReg), .seqWrInj(seqWrInj),
    .smpLast(smpLast), .regLen(regLen), .injLen(injLen),
    .chSel(chSel), .regData(regData), .injData(injData),
    .eocReg(eocReg), .eocInj(eocInj), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
  import conv_seq_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            smpActive,
  input logic            cnvActive,
  input logic [CH_W-1:0] chSel,
  input logic            eocReg,
  input logic            eocInj,
  input logic            dmaReq,
  input logic            dmaAck
);
  AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (chSel < CH_W'(NUM_CH))); // R2
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({smpActive, cnvActive})); // R4
  AST_EOC_AFTER_CONV: assert property (@(posedge clk) disable iff (!rstN)
    (eocReg || eocInj) |-> $past(cnvActive)); // R4
  AST_CH_STABLE_CONV: assert property (@(posedge clk) disable iff (!rstN)
    (cnvActive && $past(cnvActive)) |-> $stable(chSel)); // R4
  AST_EOC_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(eocReg && eocInj)); // R5
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck) |=> dmaReq); // R6
  AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> eocReg); // R6
  AST_INJ_NO_DMA: assert property (@(posedge clk) disable iff (!rstN)
    eocInj |-> !$rose(dmaReq)); // R7
endmodule

bind conv_seq_top conv_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .smpActive(smpActive),
  .cnvActive(cnvActive), .chSel(chSel), .eocReg(eocReg), .eocInj(eocInj),
  .dmaReq(dmaReq), .dmaAck(dmaAck)
);

// File: tb/sim_conv_seq_top.sv
`timescale 1ns/1ps
module sim_conv_seq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        startReg = 1'b0;
  logic        startInj = 1'b0;
  logic [11:0] adcData;
  logic        dmaAck = 1'b0;
  logic [3:0]  chSel;
  logic        smpActive, cnvActive, busy, eocReg, eocInj, dmaReq;
  logic [11:0] regData;
  logic [47:0] injData;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int code [10] = '{0, 0, 0, 2, 0, 7, 0, 1, 0, 3};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Converter stub: output word depends only on the selected channel.
  always_comb adcData = 12'(chSel) * 12'h111 + 12'h003;

  conv_seq_top u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .startReg(startReg), .startInj(startInj), .adcData(adcData), .dmaAck(dmaAck),
    .chSel(chSel), .smpActive(smpActive), .cnvActive(cnvActive), .busy(busy),
    .eocReg(eocReg), .eocInj(eocInj), .regData(regData), .injData(injData),
    .dmaReq(dmaReq)
  );

  function automatic logic [11:0] expData(input int ch);
    return 12'(ch * 12'h111 + 3);
  endfunction

  function automatic int smpN(input int ch);
    return 3 + 4 * code[ch];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic pulseStart(input bit r, input bit i);
    startReg = r; startInj = i;
    @(posedge clk); #1;
    startReg = 1'b0; startInj = 1'b0;
  endtask

  task automatic waitEoc(output int k, output int nS, output int nC,
                         output bit gR, output bit gI);
    k = 0; nS = 0; nC = 0;
    do begin
      @(negedge clk);
      k++;
      if (!(eocReg || eocInj)) begin
        nS += int'(smpActive);
        nC += int'(cnvActive);
      end
    end while (!(eocReg || eocInj) && k < 300);
    gR = eocReg; gI = eocInj;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(eocReg == 0 && eocInj == 0, "R1", "eoc", {eocReg, eocInj}, 0);
    chk(dmaReq == 0, "R1", "dmaReq", dmaReq, 0);
    chk(regData == 0, "R1", "regData", regData, 0);
    chk(injData == 0, "R1", "injData", injData, 0);
    chk(chSel == 0, "R1", "chSel", chSel, 0);
  endtask

  task automatic t_timing(input int ch);
    int k, nS, nC; bit gR, gI;
    wr(3'd1, 32'd0);
    wr(3'd2, 32'(ch));
    @(negedge clk);
    chk(busy == 0, "R9", "idle write starts nothing", busy, 0);
    pulseStart(1, 0);
    @(negedge clk);
    chk(busy == 1, "R11", "busy after start", busy, 1);
    chk(chSel == 4'(ch), "R2", "chSel", chSel, ch);
    // one observation consumed above
    waitEoc(k, nS, nC, gR, gI);
    k++; nS++;
    chk(k == smpN(ch) + 12, "R4", "result latency", k, smpN(ch) + 12);
    chk(nS == smpN(ch), "R4", "sample cycles", nS, smpN(ch));
    chk(nC == 11, "R4", "convert cycles", nC, 11);
    chk(gR && !gI, "R5", "regular pulse", {gR, gI}, 2);
    chk(regData == expData(ch), "R5", "regData", regData, expData(ch));
    chk(busy == 0, "R11", "busy at last result", busy, 0);
    @(negedge clk);
    chk(eocReg == 0, "R5", "pulse one cycle", eocReg, 0);
  endtask

  task automatic t_sequence();
    int k, nS, nC; bit gR, gI;
    int chs [4] = '{7, 2, 9, 0};
    wr(3'd1, 32'd3);
    wr(3'd2, 32'h0000_0C27);   // slot2 field 12 selects channel 9
    pulseStart(1, 0);
    for (int s = 0; s < 4; s++) begin
      int ex;
      waitEoc(k, nS, nC, gR, gI);
      ex = smpN(chs[s]) + (s == 0 ? 12 : 11);
      chk(k == ex, "R4", "back-to-back spacing", k, ex);
      chk(gR && !gI, "R2", "regular pulse", {gR, gI}, 2);
      chk(regData == expData(chs[s]), "R2", "slot order data", regData, expData(chs[s]));
      chk(busy == (s != 3), "R11", "busy", busy, s != 3);
    end
  endtask

  task automatic t_injected();
    int k, nS, nC; bit gR, gI;
    int chs [3] = '{5, 3, 8};
    wr(3'd0, 32'd1);
    wr(3'd4, 32'h0002_1835);
    pulseStart(0, 1);
    for (int s = 0; s < 3; s++) begin
      int ex;
      waitEoc(k, nS, nC, gR, gI);
      ex = smpN(chs[s]) + (s == 0 ? 12 : 11);
      chk(k == ex, "R3", "injected spacing", k, ex);
      chk(gI && !gR, "R3", "injected pulse", {gR, gI}, 1);
      chk(injData[12*s +: 12] == expData(chs[s]), "R3", "slot result",
          injData[12*s +: 12], expData(chs[s]));
      chk(dmaReq == 0, "R7", "no DMA for injected", dmaReq, 0);
    end
    chk(injData[47:36] == 0, "R3", "unused slice", injData[47:36], 0);
    chk(busy == 0, "R11", "busy end injected", busy, 0);
  endtask

  task automatic t_dma();
    int k, nS, nC; bit gR, gI;
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'h0000_0002);
    pulseStart(1, 0);
    waitEoc(k, nS, nC, gR, gI);
    chk(dmaReq == 1, "R6", "request at result", dmaReq, 1);
    waitEoc(k, nS, nC, gR, gI);
    chk(dmaReq == 1, "R6", "request held", dmaReq, 1);
    idleCycles(4);
    chk(dmaReq == 1, "R6", "request held without ack", dmaReq, 1);
    dmaAck = 1'b1;
    @(posedge clk); #1;
    dmaAck = 1'b0;
    @(negedge clk);
    chk(dmaReq == 0, "R6", "ack clears", dmaReq, 0);
    wr(3'd0, 32'd0);
    pulseStart(1, 0);
    waitEoc(k, nS, nC, gR, gI);
    chk(gR && dmaReq == 0, "R6", "DMA disabled", dmaReq, 0);
    waitEoc(k, nS, nC, gR, gI);
    chk(dmaReq == 0, "R6", "DMA disabled second", dmaReq, 0);
  endtask

  task automatic t_busyStart();
    int k, nS, nC; bit gR, gI;
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd5);
    pulseStart(1, 0);
    idleCycles(5);
    pulseStart(1, 1);
    waitEoc(k, nS, nC, gR, gI);
    chk(k + 5 == smpN(5) + 12, "R8", "schedule unchanged", k + 5, smpN(5) + 12);
    chk(gR && !gI, "R8", "ignored start", {gR, gI}, 2);
    idleCycles(30);
    chk(busy == 0 && eocInj == 0, "R8", "no late injected run", {busy, eocInj}, 0);
  endtask

  task automatic t_abort();
    int k, nS, nC; bit gR, gI;
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd5);
    pulseStart(1, 0);
    idleCycles(5);
    wr(3'd4, 32'd7);          // injected, one slot, channel 7
    waitEoc(k, nS, nC, gR, gI);
    chk(k == smpN(7) + 12, "R9", "restart latency", k, smpN(7) + 12);
    chk(gI && !gR, "R9", "aborted group silent", {gR, gI}, 1);
    chk(injData[11:0] == expData(7), "R9", "restart result", injData[11:0], expData(7));
    pulseStart(0, 1);
    idleCycles(3);
    wr(3'd5, 32'h0000_0000 | (2 << 9) | (7 << 15) | (1 << 21) | (3 << 27));
    wr(3'd2, 32'd9);          // regular rewrite aborts injected
    waitEoc(k, nS, nC, gR, gI);
    chk(k == smpN(9) + 12, "R9", "regular restart latency", k, smpN(9) + 12);
    chk(gR && !gI, "R9", "injected aborted", {gR, gI}, 2);
    chk(regData == expData(9), "R9", "regular restart data", regData, expData(9));
  endtask

  task automatic t_priority();
    int k, nS, nC; bit gR, gI;
    wr(3'd2, 32'd0);
    wr(3'd4, 32'd1);
    pulseStart(1, 1);
    waitEoc(k, nS, nC, gR, gI);
    chk(gI && !gR, "R10", "injected wins", {gR, gI}, 1);
    chk(k == smpN(1) + 12, "R10", "latency", k, smpN(1) + 12);
    chk(busy == 0, "R10", "regular not queued", busy, 0);
  endtask

  task automatic t_full();
    int k, nS, nC; bit gR, gI;
    int ch [16];
    for (int s = 0; s < 8; s++) ch[s] = s;
    for (int s = 8; s < 16; s++) ch[s] = (s % 2 == 0) ? 8 : 9;
    wr(3'd1, 32'd15);
    wr(3'd2, 32'h7654_3210);
    wr(3'd3, 32'h9898_9898);
    pulseStart(1, 0);
    for (int s = 0; s < 16; s++) begin
      int ex;
      waitEoc(k, nS, nC, gR, gI);
      ex = smpN(ch[s]) + (s == 0 ? 12 : 11);
      chk(k == ex && gR, "R2", "sixteen-slot timing", k, ex);
      chk(regData == expData(ch[s]), "R2", "sixteen-slot data", regData, expData(ch[s]));
    end
    chk(busy == 0, "R11", "busy after slot 15", busy, 0);
  endtask

  initial begin
    idleCycles(4);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    wr(3'd5, 32'h0000_0000 | (2 << 9) | (7 << 15) | (1 << 21) | (3 << 27));
    t_timing(3);
    t_timing(5);
    t_sequence();
    t_injected();
    t_dma();
    t_busyStart();
    t_abort();
    t_priority();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule